// File: doc/BRIEF.md
# Configurable Product-Term Logic Macrocell

The block is one logic cell of a sum-of-products fabric. It takes 36 routed input signals and 16 expander terms, and forms five product terms. Each term is an AND of a chosen set of those inputs, where each chosen input is used either as it is or inverted. A static configuration vector sets the masks. It also steers each term to one of eight places: the main sum, a second sum, register clear, register preset, clock enable, product-term clock, the polarity XOR, or the chain output that lends a term to the next cell.

The main sum, with the neighbour's parallel-expander input ORed in, passes through a polarity XOR. The result then goes either straight to the outputs (bypass) or into a register that can act as a D, T, JK or SR flip-flop. The register clock is one of two global clock inputs or the product-term clock. Every clock source is sampled under the single system clock, and the register advances on a rising edge of the source. One configurable term also leaves the cell in inverted form, so that other cells can use it as an expander.

Top module: `ptl_macrocell`

Configuration layout. Let N = 52 be the number of term inputs. The term input vector places `route_in[i]` at index i and `exp_in[j]` at index 36+j. For term k, the true mask starts at bit k*2N and the inverted mask at bit k*2N+N. The route codes start at bit 520, three bits per term. The flags start at bit 535 and sit at these offsets from there:

| Offset | Width | Flag |
|---|---|---|
| +0 | 1 | polarity |
| +1 | 2 | flip-flop type |
| +3 | 1 | bypass |
| +4 | 2 | clock source |
| +6 | 1 | enable-on |
| +7 | 1 | clear source |
| +8 | 1 | fast input |
| +9 | 3 | share select |

## Requirements
- R1: Term k is 1 exactly when every input whose true-mask bit is set is 1 and every input whose inverted-mask bit is set is 0. A term with no mask bits set is 1. A term whose true-mask and inverted-mask bits are both set for the same input is always 0.
- R2: Route codes are 0 main sum, 1 second sum, 2 clear, 3 preset, 4 enable, 5 clock, 6 polarity XOR and 7 chain. `chain_out` is the OR of the code-7 terms. `par_in` is ORed into the main sum.
- R3: `share_out` is the inverse of the term picked by share select. A share select value of 5 or above gives 1.
- R4: The logic result is the main sum XOR (polarity flag XOR the OR of the code-6 terms). With bypass set to 1, `pin_out` and `fb_out` show the logic result in the same cycle.
- R5: In D mode (type 0), a clock tick loads the data input. The data input is `pin_in` when the fast-input flag is 1, and the logic result otherwise. With bypass set to 0, the outputs show the register.
- R6: In T mode (type 1), a tick inverts the register when the data input is 1 and keeps it when the data input is 0.
- R7: In JK mode (type 2), J is the data input and K is the second sum. On a tick, 00 holds, 10 sets, 01 clears and 11 toggles.
- R8: In SR mode (type 3), S is the data input and R is the second sum. On a tick, 10 sets, 01 clears, and 00 or 11 holds.
- R9: Clock source 0 selects `gclk[0]`, 1 selects `gclk[1]`, and 2 or 3 selects the OR of the code-5 terms. A tick occurs at a system-clock edge where the selected source is 1 and was 0 at the previous edge. Without a tick, the register keeps its value.
- R10: With enable-on set to 1, a tick has no effect while the OR of the code-4 terms is 0. With enable-on set to 0, every tick counts.
- R11: Clear comes from `gclr` when the clear-source flag is 0, and from the OR of the code-2 terms when it is 1. Preset is the OR of the code-3 terms. Clear forces the register to 0 and preset forces it to 1. Both take effect in the same cycle and the value persists afterwards. Clear overrides preset and any tick.
- R12: While `rst_n` is 0 at a system-clock edge, the register becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg | input | 547 | Static configuration vector |
| route_in | input | 36 | Routed input signals |
| exp_in | input | 16 | Expander term inputs |
| par_in | input | 1 | Parallel-expander input from neighbour |
| pin_in | input | 1 | Direct pin input for fast data path |
| gclk | input | 2 | Global clock sources |
| gclr | input | 1 | Global clear, active high |
| pin_out | output | 1 | Cell output toward the pin side |
| fb_out | output | 1 | Cell output back to routing |
| share_out | output | 1 | Inverted shareable expander term |
| chain_out | output | 1 | Parallel-expander chain output |

## Verification
The term, share, chain and bypass results are combinational and settle in the cycle of the stimulus. A registered result is due just after the first system-clock rising edge at which the selected clock source is seen high after being low. Clear and preset act in the cycle they are applied. The bench drives each stimulus at a falling edge and records the expected outputs in a queue. A monitor checks each entry 2 ns after the next rising edge, when both kinds of result are settled. A clock pulse is always followed by a step with the source low, so that the next tick comes from a fresh rising edge.

// File: rtl/ptl_pkg.sv
// Package: shared encodings for the product-term macrocell.
// Holds the route codes, the flip-flop type codes and the offsets of the
// single-bit and small fields inside the flag area of the configuration vector.
package ptl_pkg;

    localparam int RT_W = 3;

    typedef enum logic [RT_W-1:0] {
        RT_SUM_A = 3'd0,
        RT_SUM_B = 3'd1,
        RT_CLR   = 3'd2,
        RT_PRE   = 3'd3,
        RT_ENA   = 3'd4,
        RT_CLK   = 3'd5,
        RT_XOR   = 3'd6,
        RT_CHAIN = 3'd7
    } route_e;

    typedef enum logic [1:0] {
        FF_D  = 2'd0,
        FF_T  = 2'd1,
        FF_JK = 2'd2,
        FF_SR = 2'd3
    } ff_e;

    // Offsets from the start of the flag area.
    localparam int F_XOR   = 0;
    localparam int F_FF    = 1;
    localparam int F_BYP   = 3;
    localparam int F_CLK   = 4;
    localparam int F_ENA   = 6;
    localparam int F_CLRS  = 7;
    localparam int F_FAST  = 8;
    localparam int F_SHARE = 9;

endpackage

// File: rtl/ptl_term_array.sv
// Module: ptl_term_array
// Forms N_PT product terms over N_IN literals.
// Each term has a true mask and an inverted mask of N_IN bits, packed as
// {inverted, true} per term. An empty mask gives 1.
// Assumes the masks are static while the block is in use.
module ptl_term_array #(
    parameter int N_IN = 52,
    parameter int N_PT = 5
) (
    input  logic [N_IN-1:0]        lit,
    input  logic [2*N_IN*N_PT-1:0] masks,
    output logic [N_PT-1:0]        pt
);

    for (genvar k = 0; k < N_PT; k++) begin : g_term
        logic [N_IN-1:0] tm;
        logic [N_IN-1:0] cm;
        assign tm = masks[k*2*N_IN +: N_IN];
        assign cm = masks[k*2*N_IN + N_IN +: N_IN];
        // One term: every true-masked literal high and every inverted-masked literal low.
        assign pt[k] = (&(~tm | lit)) & (&(~cm | ~lit));
    end

endmodule

// File: rtl/ptl_select_matrix.sv
// Module: ptl_select_matrix
// Steers each product term to one of eight destinations by its route code,
// ORs the terms that share a destination, and forms the polarity-adjusted
// logic result.
// Assumes the route codes are static.
module ptl_select_matrix
    import ptl_pkg::*;
#(
    parameter int N_PT = 5
) (
    input  logic [N_PT-1:0]      pt,
    input  logic [RT_W*N_PT-1:0] route,
    input  logic                 par_in,
    input  logic                 xor_pol,
    output logic                 sum_b,
    output logic                 clr_pt,
    output logic                 pre_pt,
    output logic                 ena_pt,
    output logic                 clk_pt,
    output logic                 chain_out,
    output logic                 logic_out
);

    localparam int N_DEST = 1 << RT_W;

    logic [N_DEST-1:0] grp;
    logic              sum_a;

    // Collect the OR of terms for each destination.
    always_comb begin
        grp = '0;
        for (int k = 0; k < N_PT; k++) begin
            grp[route[k*RT_W +: RT_W]] = grp[route[k*RT_W +: RT_W]] | pt[k];
        end
    end

    // Fan the destination groups out to the named outputs.
    always_comb begin
        sum_a     = grp[RT_SUM_A] | par_in;
        sum_b     = grp[RT_SUM_B];
        clr_pt    = grp[RT_CLR];
        pre_pt    = grp[RT_PRE];
        ena_pt    = grp[RT_ENA];
        clk_pt    = grp[RT_CLK];
        chain_out = grp[RT_CHAIN];
        logic_out = sum_a ^ (xor_pol ^ grp[RT_XOR]);
    end

endmodule

// File: rtl/ptl_register.sv
// Module: ptl_register
// Configurable flip-flop for the macrocell. It detects a rising edge of its
// clock source under the system clock and updates as D, T, JK or SR.
// Clear and preset override the stored value at once and persist.
// Assumes clk_src is synchronous to clk.
module ptl_register
    import ptl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_src,
    input  logic ena,
    input  ff_e  ff_type,
    input  logic d_a,
    input  logic d_b,
    input  logic clr,
    input  logic pre,
    output logic q,
    output logic tick
);

    logic src_q;
    logic q_r;
    logic nxt;

    // Remember the clock source from the previous edge for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= clk_src;
    end

    assign tick = clk_src & ~src_q;

    // Next state for the selected flip-flop type.
    always_comb begin
        unique case (ff_type)
            FF_D:    nxt = d_a;
            FF_T:    nxt = q_r ^ d_a;
            FF_JK:   nxt = (d_a & ~q_r) | (~d_b & q_r);
            default: nxt = (d_a & ~d_b) ? 1'b1 : ((d_b & ~d_a) ? 1'b0 : q_r);
        endcase
    end

    // Stored state: reset, then clear, then preset, then a gated tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          q_r <= 1'b0;
        else if (clr)        q_r <= 1'b0;
        else if (pre)        q_r <= 1'b1;
        else if (tick & ena) q_r <= nxt;
    end

    // Visible state, with clear and preset acting at once.
    assign q = clr ? 1'b0 : (pre ? 1'b1 : q_r);

endmodule

// File: rtl/ptl_macrocell.sv
// Module: ptl_macrocell (top)
// Product-term logic cell. It builds the terms, routes them to logic or to
// register control, and drives the pin and feedback outputs from the
// register or from the bypass path. It also drives the shareable expander
// and the chain output.
// Assumes cfg is static, and that gclk and gclr are synchronous to clk.
module ptl_macrocell
    import ptl_pkg::*;
#(
    parameter int N_ROUTE = 36,
    parameter int N_EXP   = 16,
    parameter int N_PT    = 5,
    localparam int N_IN   = N_ROUTE + N_EXP,
    localparam int TERM_W = 2 * N_IN * N_PT,
    localparam int RT_B   = TERM_W,
    localparam int MISC_B = RT_B + RT_W * N_PT,
    localparam int SEL_W  = $clog2(N_PT),
    localparam int CFG_W  = MISC_B + F_SHARE + SEL_W
) (
    input  logic [CFG_W-1:0]   cfg,
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_ROUTE-1:0] route_in,
    input  logic [N_EXP-1:0]   exp_in,
    input  logic               par_in,
    input  logic               pin_in,
    input  logic [1:0]         gclk,
    input  logic               gclr,
    output logic               pin_out,
    output logic               fb_out,
    output logic               share_out,
    output logic               chain_out
);

    logic [N_PT-1:0]  pt;
    logic [SEL_W-1:0] share_sel;
    logic             sum_b, clr_pt, pre_pt, ena_pt, clk_pt, logic_out;
    logic             clk_src, ena_eff, clr_eff, data_a, reg_q, reg_tick;
    logic             bypass;
    ff_e              ff_sel;

    ptl_term_array #(.N_IN(N_IN), .N_PT(N_PT)) u_terms (
        .lit   ({exp_in, route_in}),
        .masks (cfg[TERM_W-1:0]),
        .pt    (pt)
    );

    ptl_select_matrix #(.N_PT(N_PT)) u_matrix (
        .pt        (pt),
        .route     (cfg[RT_B +: RT_W*N_PT]),
        .par_in    (par_in),
        .xor_pol   (cfg[MISC_B + F_XOR]),
        .sum_b     (sum_b),
        .clr_pt    (clr_pt),
        .pre_pt    (pre_pt),
        .ena_pt    (ena_pt),
        .clk_pt    (clk_pt),
        .chain_out (chain_out),
        .logic_out (logic_out)
    );

    // Decode the register control flags and pick the clock, enable, clear and data.
    always_comb begin
        ff_sel    = ff_e'(cfg[MISC_B + F_FF +: 2]);
        bypass    = cfg[MISC_B + F_BYP];
        share_sel = cfg[MISC_B + F_SHARE +: SEL_W];
        unique case (cfg[MISC_B + F_CLK +: 2])
            2'd0:    clk_src = gclk[0];
            2'd1:    clk_src = gclk[1];
            default: clk_src = clk_pt;
        endcase
        ena_eff = cfg[MISC_B + F_ENA]  ? ena_pt : 1'b1;
        clr_eff = cfg[MISC_B + F_CLRS] ? clr_pt : gclr;
        data_a  = cfg[MISC_B + F_FAST] ? pin_in : logic_out;
    end

    ptl_register u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_src (clk_src),
        .ena     (ena_eff),
        .ff_type (ff_sel),
        .d_a     (data_a),
        .d_b     (sum_b),
        .clr     (clr_eff),
        .pre     (pre_pt),
        .q       (reg_q),
        .tick    (reg_tick)
    );

    // Shareable expander: the inverse of the picked term, 1 when the pick is out of range.
    always_comb begin
        share_out = 1'b1;
        for (int k = 0; k < N_PT; k++) begin
            if (int'(share_sel) == k) share_out = ~pt[k];
        end
    end

    // Output selection between the register and the bypass path.
    always_comb begin
        pin_out = bypass ? logic_out : reg_q;
        fb_out  = pin_out;
    end

endmodule

// File: rtl/ptl_macrocell_chk.sv
// Module: ptl_macrocell_chk
// Assertion checker bound to ptl_macrocell. It watches the register
// controls produced by the routing logic against the register and the
// output port.
// Assumes it is attached through the bind statement below.
module ptl_macrocell_chk
    import ptl_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic pin_out,
    input logic bypass,
    input logic q,
    input logic tick,
    input logic ena,
    input logic clr,
    input logic pre,
    input ff_e  ff_type,
    input logic d_a
);

    // R11: an active clear shows 0 on the output when the register drives it.
    a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !bypass) |-> !pin_out);

    // R11: a preset without a clear shows 1 on the output.
    a_r11_preset_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pre && !clr && !bypass) |-> pin_out);

    // R9: with no tick and no override, the register holds.
    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr && !pre) |=> (clr || pre || $stable(q)));

    // R10: a tick with the enable low leaves the register unchanged.
    a_r10_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ena && !clr && !pre) |=> (clr || pre || $stable(q)));

    // R5: in D mode an enabled tick loads the data input.
    a_r5_d_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ena && !clr && !pre && ff_type == FF_D) |=> (clr || pre || q == $past(d_a)));

    // R6: in T mode an enabled tick with data 1 inverts the register.
    a_r6_t_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ena && !clr && !pre && ff_type == FF_T && d_a) |=> (clr || pre || q != $past(q)));

endmodule

bind ptl_macrocell ptl_macrocell_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_out (pin_out),
    .bypass  (bypass),
    .q       (reg_q),
    .tick    (reg_tick),
    .ena     (ena_eff),
    .clr     (clr_eff),
    .pre     (pre_pt),
    .ff_type (ff_sel),
    .d_a     (data_a)
);

// File: tb/ptl_macrocell_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard for ptl_macrocell.
// A driver task applies inputs at a falling edge and queues the expected outputs.
// A monitor pops each entry 2 ns after the next rising edge and compares.
module ptl_macrocell_bench;

    localparam int NR    = 36;
    localparam int NE    = 16;
    localparam int NP    = 5;
    localparam int NI    = NR + NE;
    localparam int RTB   = 2 * NI * NP;
    localparam int MISC  = RTB + 3 * NP;
    localparam int CFGW  = MISC + 9 + 3;

    typedef struct {
        logic  pin;
        logic  share;
        logic  chain;
        string tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CFGW-1:0] cfg = '0;
    logic [NR-1:0]   route_in = '0;
    logic [NE-1:0]   exp_in = '0;
    logic            par_in = 1'b0;
    logic            pin_in = 1'b0;
    logic [1:0]      gclk = 2'b00;
    logic            gclr = 1'b0;
    logic            pin_out, fb_out, share_out, chain_out;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    always #4 clk = ~clk;

    ptl_macrocell u_ptl_macrocell (
        .cfg       (cfg),
        .clk       (clk),
        .rst_n     (rst_n),
        .route_in  (route_in),
        .exp_in    (exp_in),
        .par_in    (par_in),
        .pin_in    (pin_in),
        .gclk      (gclk),
        .gclr      (gclr),
        .pin_out   (pin_out),
        .fb_out    (fb_out),
        .share_out (share_out),
        .chain_out (chain_out)
    );

    // Monitor: compare the queued expectation shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_checks++;
            if (pin_out !== it.pin || fb_out !== it.pin ||
                share_out !== it.share || chain_out !== it.chain) begin
                n_fails++;
                $display("FAIL %s: pin/fb/share/chain = %b/%b/%b/%b expected %b/%b/%b/%b",
                         it.tag, pin_out, fb_out, share_out, chain_out,
                         it.pin, it.pin, it.share, it.chain);
            end
        end
    end

    task automatic term_kill(int k);
        cfg[k*2*NI +: 2*NI] = '0;
        cfg[k*2*NI]         = 1'b1;
        cfg[k*2*NI + NI]    = 1'b1;
    endtask

    task automatic term_empty(int k);
        cfg[k*2*NI +: 2*NI] = '0;
    endtask

    task automatic term_lit(int k, int idx, bit neg);
        cfg[k*2*NI + (neg ? NI : 0) + idx] = 1'b1;
    endtask

    task automatic term_route(int k, int code);
        cfg[RTB + 3*k +: 3] = code[2:0];
    endtask

    task automatic cfg_base();
        cfg = '0;
        for (int k = 0; k < NP; k++) begin
            term_kill(k);
            term_route(k, 7);
        end
    endtask

    // Driver: apply one stimulus and queue what the outputs must show one edge later.
    task automatic step(logic [NR-1:0] r, logic [NE-1:0] e, logic par, logic pin,
                        logic [1:0] gk, logic gc, logic xp, logic xs, logic xc, string tag);
        exp_t it;
        @(negedge clk);
        route_in = r; exp_in = e; par_in = par; pin_in = pin; gclk = gk; gclr = gc;
        it.pin = xp; it.share = xs; it.chain = xc; it.tag = tag;
        exp_q.push_back(it);
        @(posedge clk);
        #3;
    endtask

    // Register-phase step: term 0 follows route_in[0], so share is its inverse and chain is 0.
    task automatic rstep(logic [NR-1:0] r, logic [1:0] gk, logic gc, logic pin,
                         logic xp, string tag);
        step(r, '0, 1'b0, pin, gk, gc, xp, ~r[0], 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        cfg_base();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: the register starts at 0 after reset.
        step('0, '0, 0, 0, 2'b00, 0, 1'b0, 1'b1, 1'b0, "R12 reset state");

        // Bypass phase: term 0 = route_in[3] AND NOT exp_in[2], routed to the main sum.
        cfg[MISC + 3] = 1'b1;
        term_empty(0); term_lit(0, 3, 0); term_lit(0, NR + 2, 1); term_route(0, 0);
        step(36'h008, '0,      0, 0, 2'b00, 0, 1'b1, 1'b0, 1'b0, "R1 term true");
        step(36'h008, 16'h004, 0, 0, 2'b00, 0, 1'b0, 1'b1, 1'b0, "R1 inverted literal");
        step('0,      '0,      0, 0, 2'b00, 0, 1'b0, 1'b1, 1'b0, "R1 true literal low");
        step('0,      '0,      1, 0, 2'b00, 0, 1'b1, 1'b1, 1'b0, "R2 parallel expander");
        // R4: polarity flag plus an empty term on the XOR path.
        cfg[MISC + 0] = 1'b1;
        term_empty(1); term_route(1, 6);
        step(36'h008, '0, 0, 0, 2'b00, 0, 1'b1, 1'b0, 1'b0, "R4 xor both ones");
        step('0,      '0, 0, 0, 2'b00, 0, 1'b0, 1'b1, 1'b0, "R4 xor cancels");
        term_kill(1);
        step('0,      '0, 0, 0, 2'b00, 0, 1'b1, 1'b1, 1'b0, "R4 polarity inverts");
        cfg[MISC + 0] = 1'b0;
        term_empty(2); term_route(2, 7);
        step('0, '0, 0, 0, 2'b00, 0, 1'b0, 1'b1, 1'b1, "R2 chain from empty term");
        cfg[MISC + 9 +: 3] = 3'd2;
        step('0, '0, 0, 0, 2'b00, 0, 1'b0, 1'b0, 1'b1, "R3 share picks term 2");
        term_kill(2);
        step('0, '0, 0, 0, 2'b00, 0, 1'b0, 1'b1, 1'b0, "R3 share of killed term");
        cfg[MISC + 9 +: 3] = 3'd6;
        step('0, '0, 0, 0, 2'b00, 0, 1'b0, 1'b1, 1'b0, "R3 share out of range");

        // Register phase: D mode on gclk[0], term 0 = route_in[0] on the main sum.
        cfg_base();
        term_empty(0); term_lit(0, 0, 0); term_route(0, 0);
        rstep(36'h001, 2'b01, 0, 0, 1'b1, "R5 D loads 1");
        rstep(36'h000, 2'b00, 0, 0, 1'b1, "R9 no tick holds");
        rstep(36'h000, 2'b01, 0, 0, 1'b0, "R5 D loads 0");
        cfg[MISC + 8] = 1'b1;
        rstep(36'h000, 2'b00, 0, 1, 1'b0, "R5 fast input waits for tick");
        rstep(36'h000, 2'b01, 0, 1, 1'b1, "R5 fast input loads pin");
        cfg[MISC + 8] = 1'b0;
        rstep(36'h000, 2'b00, 0, 0, 1'b1, "R9 hold");
        rstep(36'h000, 2'b10, 0, 0, 1'b1, "R9 unselected clock ignored");
        rstep(36'h000, 2'b00, 0, 0, 1'b1, "R9 hold");
        // R9: product-term clock from route_in[5].
        cfg[MISC + 4 +: 2] = 2'd2;
        term_empty(3); term_lit(3, 5, 0); term_route(3, 5);
        rstep(36'h020, 2'b00, 0, 0, 1'b0, "R9 term clock loads 0");
        rstep(36'h001, 2'b00, 0, 0, 1'b0, "R9 term clock low holds");
        rstep(36'h021, 2'b00, 0, 0, 1'b1, "R9 term clock loads 1");
        rstep(36'h000, 2'b00, 0, 0, 1'b1, "R9 hold");
        // R10: enable from route_in[6].
        cfg[MISC + 6] = 1'b1;
        term_empty(4); term_lit(4, 6, 0); term_route(4, 4);
        rstep(36'h020, 2'b00, 0, 0, 1'b1, "R10 enable low blocks tick");
        rstep(36'h000, 2'b00, 0, 0, 1'b1, "R10 hold");
        rstep(36'h060, 2'b00, 0, 0, 1'b0, "R10 enable high passes tick");
        rstep(36'h000, 2'b00, 0, 0, 1'b0, "R10 hold");
        cfg[MISC + 6] = 1'b0;
        term_kill(4); term_route(4, 7);
        cfg[MISC + 4 +: 2] = 2'd0;
        // R6: T mode.
        cfg[MISC + 1 +: 2] = 2'd1;
        rstep(36'h001, 2'b01, 0, 0, 1'b1, "R6 toggle to 1");
        rstep(36'h001, 2'b00, 0, 0, 1'b1, "R6 hold between ticks");
        rstep(36'h001, 2'b01, 0, 0, 1'b0, "R6 toggle to 0");
        rstep(36'h000, 2'b00, 0, 0, 1'b0, "R6 hold");
        rstep(36'h000, 2'b01, 0, 0, 1'b0, "R6 data 0 keeps");
        rstep(36'h000, 2'b00, 0, 0, 1'b0, "R6 hold");
        // R7: JK mode, K from route_in[1] on the second sum.
        cfg[MISC + 1 +: 2] = 2'd2;
        term_empty(1); term_lit(1, 1, 0); term_route(1, 1);
        rstep(36'h001, 2'b01, 0, 0, 1'b1, "R7 J sets");
        rstep(36'h000, 2'b00, 0, 0, 1'b1, "R7 hold");
        rstep(36'h000, 2'b01, 0, 0, 1'b1, "R7 00 holds");
        rstep(36'h000, 2'b00, 0, 0, 1'b1, "R7 hold");
        rstep(36'h003, 2'b01, 0, 0, 1'b0, "R7 11 toggles to 0");
        rstep(36'h000, 2'b00, 0, 0, 1'b0, "R7 hold");
        rstep(36'h003, 2'b01, 0, 0, 1'b1, "R7 11 toggles to 1");
        rstep(36'h000, 2'b00, 0, 0, 1'b1, "R7 hold");
        rstep(36'h002, 2'b01, 0, 0, 1'b0, "R7 K clears");
        rstep(36'h000, 2'b00, 0, 0, 1'b0, "R7 hold");
        // R8: SR mode.
        cfg[MISC + 1 +: 2] = 2'd3;
        rstep(36'h003, 2'b01, 0, 0, 1'b0, "R8 both hold at 0");
        rstep(36'h000, 2'b00, 0, 0, 1'b0, "R8 hold");
        rstep(36'h001, 2'b01, 0, 0, 1'b1, "R8 S sets");
        rstep(36'h000, 2'b00, 0, 0, 1'b1, "R8 hold");
        rstep(36'h003, 2'b01, 0, 0, 1'b1, "R8 both hold at 1");
        rstep(36'h000, 2'b00, 0, 0, 1'b1, "R8 hold");
        rstep(36'h002, 2'b01, 0, 0, 1'b0, "R8 R clears");
        rstep(36'h000, 2'b00, 0, 0, 1'b0, "R8 hold");
        // R11: preset from route_in[7], clear from gclr then from route_in[8].
        cfg[MISC + 1 +: 2] = 2'd0;
        term_empty(2); term_lit(2, 7, 0); term_route(2, 3);
        rstep(36'h080, 2'b00, 0, 0, 1'b1, "R11 preset sets");
        rstep(36'h000, 2'b00, 0, 0, 1'b1, "R11 preset persists");
        rstep(36'h080, 2'b00, 1, 0, 1'b0, "R11 clear beats preset");
        rstep(36'h000, 2'b00, 0, 0, 1'b0, "R11 clear persists");
        cfg[MISC + 7] = 1'b1;
        term_empty(3); term_lit(3, 8, 0); term_route(3, 2);
        rstep(36'h080, 2'b00, 0, 0, 1'b1, "R11 preset again");
        rstep(36'h000, 2'b00, 1, 0, 1'b1, "R11 global clear deselected");
        rstep(36'h100, 2'b00, 0, 0, 1'b0, "R11 term clear");
        rstep(36'h000, 2'b00, 0, 0, 1'b0, "R11 term clear persists");
        rstep(36'h101, 2'b01, 0, 0, 1'b0, "R11 clear beats tick");
        rstep(36'h000, 2'b00, 0, 0, 1'b0, "R11 hold after clear");

        @(posedge clk);
        #3;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule